// File: doc/BRIEF.md
# Change-of-state input port controller

This block is the register face of a 48-line digital input card. It sits behind a byte-wide bus that decodes an 8-byte address window. The raw inputs are split into six groups of eight lines. Each group can be read at its own byte address, after a two-flop synchronizer. Every line is input-only.

An edge of either polarity on any line of a group is a change of state. A group whose enable bit is set records such a change in a sticky flag, and any set flag raises the interrupt output. The top address of the window has two uses. A write there loads the per-group enable mask. A read there returns the flags together with an active-low pending bit, and clears the flags. A change that arrives in the same cycle as that read is kept for the next read.

After reset a small priming machine passes through three states before edge detection begins: `ST_FILL0` moves to `ST_FILL1`, `ST_FILL1` moves to `ST_LOAD`, and `ST_LOAD` moves to `ST_WATCH`, where the machine stays. The first two steps fill the synchronizer. The `ST_LOAD` step loads the edge history from the first valid sample. In `ST_WATCH`, the only state in which changes are compared, the machine remains until the next reset.

Top module: `cosin_input_ctrl`

## Requirements
- R1: A read at offsets 0, 1, 2, 4, 5 and 6 returns input groups 0 to 5, in that order. Bit i of the byte is input 8*g+i of group g, and the byte shows the synchronized value of the inputs. The read data is valid combinationally while `bus_rd` is high.
- R2: A read at offset 3 returns 0x00.
- R3: A write to offset 7 loads bits 5:0 of the data as the enable mask, where bit n enables group n. Bits 7:6 of the written data are ignored.
- R4: A rising or a falling edge on any input of an enabled group sets that group's flag and drives `irq_out` high. This happens no later than the third rising clock edge after the input changes.
- R5: A group whose enable bit is 0 never sets its flag.
- R6: A read at offset 7 returns a status byte with these fields:
  - bits 5:0 are the group flags;
  - bit 6 is 0 when an interrupt is pending and 1 otherwise;
  - bit 7 is 0.
  
  `irq_out` is active high and equals the inverse of bit 6.
- R7: A read at offset 7 clears all flags and `irq_out` at the clock edge that ends the read. A change detected in that same cycle is kept and shows in the next read.
- R8: Clearing a group's enable bit also clears that group's pending flag.
- R9: After reset, the following hold:
  - the enable mask is 0;
  - the flags are clear;
  - `irq_out` is low;
  - the status reads 0x40.
  
  Input levels present at reset do not produce a change, even after their group is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Byte offset in the window |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, zero when no read |
| pin_in | input | 48 | Raw asynchronous inputs |
| irq_out | output | 1 | Change-of-state interrupt, active high |

## Verification
Directed patterns come first:
- a single rising edge, which separates group decoding from polarity;
- a single falling edge;
- an edge in a disabled group, which shows that the mask is honoured;
- an enable write carrying only bits 7:6, which shows that the upper bits are ignored;
- a change placed exactly in the cycle of a status read, which separates "clear then set" from "clear only".

Random iterations then pick an enable mask and XOR random bytes into random groups. Their expected status, `irq_out` level and group read-back come from bench functions. They separate per-group reporting from any-line reporting, and they catch mixing up neighbouring groups across the address gap at offset 3.

// File: rtl/cosin_pkg.sv
`timescale 1ns/1ps
package cosin_pkg;
    parameter int GRP_W = 8;
    parameter int NGRP  = 6;

    typedef enum logic [1:0] {
        ST_FILL0,
        ST_FILL1,
        ST_LOAD,
        ST_WATCH
    } prime_t;
endpackage

// File: rtl/cosin_sync.sv
`timescale 1ns/1ps
module cosin_sync #(
    parameter int W = 48
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] samp
);
    logic [W-1:0] meta_q;
    logic [W-1:0] samp_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            samp_q <= '0;
        end else begin
            meta_q <= raw;
            samp_q <= meta_q;
        end
    end

    assign samp = samp_q;
endmodule

// File: rtl/cosin_edge.sv
`timescale 1ns/1ps
module cosin_edge
    import cosin_pkg::*;
#(
    parameter int GW = GRP_W,
    parameter int NG = NGRP,
    localparam int W = GW * NG
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  samp,
    output logic [NG-1:0] grp_chg,
    output logic          watching
);
    prime_t       state_q, state_d;
    logic [W-1:0] hist_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_FILL0;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FILL0: state_d = ST_FILL1;
            ST_FILL1: state_d = ST_LOAD;
            ST_LOAD:  state_d = ST_WATCH;
            ST_WATCH: state_d = ST_WATCH;
            default:  state_d = ST_FILL0;
        endcase
    end

    // outputs
    always_comb begin
        watching = (state_q == ST_WATCH);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= samp;
    end

    for (genvar g = 0; g < NG; g++) begin : g_grp
        assign grp_chg[g] = watching && (|(samp[g*GW +: GW] ^ hist_q[g*GW +: GW]));
    end
endmodule

// File: rtl/cosin_status.sv
`timescale 1ns/1ps
module cosin_status #(
    parameter int NG = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_wr,
    input  logic [NG-1:0] en_wdata,
    input  logic          clr_rd,
    input  logic [NG-1:0] grp_chg,
    output logic [NG-1:0] en_mask,
    output logic [NG-1:0] flags,
    output logic          irq
);
    logic [NG-1:0] en_q, en_d;
    logic [NG-1:0] flags_q, flags_d;

    always_comb begin
        en_d    = en_wr ? en_wdata : en_q;
        flags_d = ((clr_rd ? '0 : flags_q) | (grp_chg & en_q)) & en_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= '0;
            flags_q <= '0;
        end else begin
            en_q    <= en_d;
            flags_q <= flags_d;
        end
    end

    assign en_mask = en_q;
    assign flags   = flags_q;
    assign irq     = |flags_q;
endmodule

// File: rtl/cosin_input_ctrl.sv
`timescale 1ns/1ps
module cosin_input_ctrl
    import cosin_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2:0]           bus_addr,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [GRP_W-1:0]     bus_wdata,
    output logic [GRP_W-1:0]     bus_rdata,
    input  logic [GRP_W*NGRP-1:0] pin_in,
    output logic                 irq_out
);
    localparam int W       = GRP_W * NGRP;
    localparam int PAD_W   = GRP_W - NGRP - 1;
    localparam logic [2:0] CTL_ADDR = 3'd7;
    localparam logic [2:0] GAP_ADDR = 3'd3;

    logic [W-1:0]    samp;
    logic [NGRP-1:0] grp_chg;
    logic [NGRP-1:0] en_mask;
    logic [NGRP-1:0] flags_q;
    logic            watching;
    logic            ctl_wr, ctl_rd;

    assign ctl_wr = bus_wr && (bus_addr == CTL_ADDR);
    assign ctl_rd = bus_rd && (bus_addr == CTL_ADDR);

    cosin_sync #(.W(W)) u_sync (
        .clk (clk), .rst_n (rst_n), .raw (pin_in), .samp (samp)
    );

    cosin_edge #(.GW(GRP_W), .NG(NGRP)) u_edge (
        .clk (clk), .rst_n (rst_n), .samp (samp),
        .grp_chg (grp_chg), .watching (watching)
    );

    cosin_status #(.NG(NGRP)) u_stat (
        .clk (clk), .rst_n (rst_n),
        .en_wr (ctl_wr), .en_wdata (bus_wdata[NGRP-1:0]),
        .clr_rd (ctl_rd), .grp_chg (grp_chg),
        .en_mask (en_mask), .flags (flags_q), .irq (irq_out)
    );

    always_comb begin
        int g;
        g = (bus_addr < GAP_ADDR) ? int'(bus_addr) : int'(bus_addr) - 1;
        bus_rdata = '0;
        if (bus_rd) begin
            if (bus_addr == CTL_ADDR)
                bus_rdata = {{PAD_W{1'b0}}, ~irq_out, flags_q};
            else if (bus_addr != GAP_ADDR)
                bus_rdata = samp[g*GRP_W +: GRP_W];
        end
    end
endmodule

// File: rtl/cosin_checker.sv
`timescale 1ns/1ps
module cosin_checker #(
    parameter int NG = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_rd,
    input logic [2:0]    bus_addr,
    input logic [7:0]    bus_rdata,
    input logic          irq_out,
    input logic [NG-1:0] flags,
    input logic [NG-1:0] en,
    input logic [NG-1:0] grp_chg,
    input logic          watching
);
    assert_gap_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 3'd3) |-> bus_rdata == 8'h00);

    assert_irq_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_out) |-> $past(|grp_chg));

    assert_masked_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (flags & ~en) == '0);

    assert_pend_polarity_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 3'd7) |-> (bus_rdata[6] == !irq_out && !bus_rdata[7]));

    assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 3'd7 && grp_chg == '0) |=> !irq_out);

    assert_prime_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !watching |-> !irq_out);
endmodule

bind cosin_input_ctrl cosin_checker #(.NG(cosin_pkg::NGRP)) u_chk (
    .clk (clk), .rst_n (rst_n), .bus_rd (bus_rd), .bus_addr (bus_addr),
    .bus_rdata (bus_rdata), .irq_out (irq_out), .flags (flags_q),
    .en (en_mask), .grp_chg (grp_chg), .watching (watching)
);

// File: tb/tb_cosin_input_ctrl.sv
`timescale 1ns/1ps
module tb_cosin_input_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [47:0] pin_in = 48'hA55A_3CC3_0FF0;
    logic        irq_out;

    int checks = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cosin_input_ctrl dut (
        .clk (clk), .rst_n (rst_n), .bus_addr (bus_addr), .bus_wr (bus_wr),
        .bus_rd (bus_rd), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .pin_in (pin_in), .irq_out (irq_out)
    );

    function automatic logic [5:0] grp_diff(logic [47:0] a, logic [47:0] b);
        logic [5:0] d;
        for (int g = 0; g < 6; g++) d[g] = (a[g*8 +: 8] != b[g*8 +: 8]);
        return d;
    endfunction

    function automatic logic [7:0] status_of(logic [5:0] f);
        return {1'b0, (f == 6'd0), f};
    endfunction

    function automatic logic [2:0] grp_addr(int g);
        return (g < 3) ? 3'(g) : 3'(g + 1);
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #500000;
        if (!done) begin
            bad++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0]  rd;
        logic [47:0] nxt;
        logic [5:0]  en;
        void'($urandom(32'd7321));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);

        // R9: reset state
        chk("R9 irq after reset", {7'd0, irq_out}, 8'h00);
        bus_read(3'd7, rd); chk("R9 status after reset", rd, 8'h40);
        bus_write(3'd7, 8'h3F); settle();
        bus_read(3'd7, rd); chk("R9 no spurious change", rd, 8'h40);

        // R1 / R2: group reads and gap
        for (int g = 0; g < 6; g++) begin
            bus_read(grp_addr(g), rd); chk("R1 group read", rd, pin_in[g*8 +: 8]);
        end
        bus_read(3'd3, rd); chk("R2 gap offset", rd, 8'h00);

        // R4: rising edge in group 0, falling edge in group 5
        pin_in[0] = 1'b1; settle();
        chk("R4 irq raised", {7'd0, irq_out}, 8'h01);
        bus_read(3'd7, rd); chk("R4 R6 status rising", rd, 8'h01);
        chk("R7 irq cleared by read", {7'd0, irq_out}, 8'h00);
        pin_in[47] = 1'b0; settle();
        bus_read(3'd7, rd); chk("R4 status falling", rd, 8'h20);

        // R5: disabled group
        bus_write(3'd7, 8'h3E);
        pin_in[3] = ~pin_in[3]; settle();
        bus_read(3'd7, rd); chk("R5 disabled group quiet", rd, 8'h40);

        // R3: upper data bits ignored
        bus_write(3'd7, 8'hC0);
        pin_in[17] = ~pin_in[17]; settle();
        bus_read(3'd7, rd); chk("R3 upper bits ignored", rd, 8'h40);

        // R8: clearing enable drops pending flag
        bus_write(3'd7, 8'h3F);
        pin_in[26] = ~pin_in[26]; settle();
        chk("R8 irq before disable", {7'd0, irq_out}, 8'h01);
        bus_write(3'd7, 8'h37);
        chk("R8 irq after disable", {7'd0, irq_out}, 8'h00);
        bus_read(3'd7, rd); chk("R8 status after disable", rd, 8'h40);

        // R7: change coinciding with status read is kept
        bus_write(3'd7, 8'h3F);
        pin_in[5] = ~pin_in[5]; settle();
        @(negedge clk);
        pin_in[12] = ~pin_in[12];
        @(negedge clk);
        bus_read(3'd7, rd); chk("R7 read during change", rd, 8'h01);
        bus_read(3'd7, rd); chk("R7 change kept", rd, 8'h02);

        // random mix
        for (int it = 0; it < 40; it++) begin
            int g;
            en = 6'($urandom);
            bus_write(3'd7, {2'($urandom), en});
            bus_read(3'd7, rd);
            nxt = pin_in;
            for (int k = 0; k < 6; k++)
                if ($urandom % 2 == 1) nxt[k*8 +: 8] = nxt[k*8 +: 8] ^ 8'($urandom);
            @(negedge clk);
            en = en & grp_diff(pin_in, nxt);
            pin_in = nxt;
            settle();
            chk("R4 R5 random irq", {7'd0, irq_out}, {7'd0, (en != 6'd0)});
            bus_read(3'd7, rd); chk("R4 R5 R6 random status", rd, status_of(en));
            g = int'($urandom % 6);
            bus_read(grp_addr(g), rd); chk("R1 random group read", rd, pin_in[g*8 +: 8]);
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule